// File: doc/BRIEF.md
# Half-Bridge Current Fault Latch

This block guards a resonant half-bridge against current faults on a cycle-by-cycle basis. It watches two digitised comparator flags from the current-sense path. One flag says the sensed current is above the overcurrent limit. The other says the current is below the minimum-load level. Once any enabled fault is seen, a sticky latch trips. While the latch is set, both gate drives are held low and the oscillator enable is withdrawn.

The mode sequencer supplies two enables. The overcurrent enable is active from the end of the warm-up phase. The undercurrent enable is active only in steady operation. The overcurrent check is continuous and has a fixed, bounded response time. The undercurrent check is taken only at the moment the low-side drive turns off. An over-temperature flag also trips the same latch, whatever the enables are. The latch is released only while the lamp-shutdown input or the supply undervoltage lockout is asserted. A release request wins over any trip in the same clock.

The flags, the shutdown input and the undervoltage input are asynchronous, so each passes through a `SYNC_STAGES`-deep synchroniser. The gate drive and the enables come from logic on the same clock.

Top module: `hb_current_guard`

## Requirements
- R1: After the synchronous active-low reset, `trip` is 0, `osc_run` is 1, and `lo_gate`/`hi_gate` follow `lo_drive`/`hi_drive`.
- R2: With `oc_arm`=1, an `oc_flag` held high sets `trip` exactly `SYNC_STAGES`+1 clock edges after the first edge that samples it (3 edges by default). This must be no more than `MAX_RESP_CYC` cycles (40 cycles, i.e. 400 ns at 100 MHz).
- R3: With `oc_arm`=0, `oc_flag` has no effect on `trip`.
- R4: With `uc_arm`=1, a high `uc_flag` sets `trip` only when the registered `lo_drive` shows a 1-to-0 transition. An undercurrent flag present while `lo_drive` stays high, or stays low, does not set `trip`.
- R5: With `uc_arm`=0, `uc_flag` has no effect, even at a low-side falling edge.
- R6: `hot_flag`=1 sets `trip` whatever the values of `oc_arm` and `uc_arm`.
- R7: While `trip`=1, `lo_gate`=0, `hi_gate`=0 and `osc_run`=0, even if the drives are high.
- R8: Once set, `trip` stays set after every fault flag returns low.
- R9: `shut_req`=1 clears `trip` after its synchroniser delay plus one edge.
- R10: `uvlo`=1 clears `trip` in the same way as `shut_req`.
- R11: While a clear request is seen by the latch, a simultaneous fault does not set it. Clear has priority over set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oc_flag | input | 1 | Sensed current above overcurrent limit (async) |
| uc_flag | input | 1 | Sensed current below minimum-load level (async) |
| hot_flag | input | 1 | Over-temperature indication (async) |
| shut_req | input | 1 | Lamp-shutdown input, clears the latch while high (async) |
| uvlo | input | 1 | Supply undervoltage lockout, clears the latch while high (async) |
| oc_arm | input | 1 | Overcurrent check enable from the sequencer |
| uc_arm | input | 1 | Undercurrent check enable from the sequencer |
| lo_drive | input | 1 | Low-side gate command from the oscillator |
| hi_drive | input | 1 | High-side gate command from the oscillator |
| lo_gate | output | 1 | Gated low-side drive |
| hi_gate | output | 1 | Gated high-side drive |
| osc_run | output | 1 | Oscillator enable, low while tripped |
| trip | output | 1 | Fault latch state |

## Verification
The assertions assume that `oc_arm`, `uc_arm` and `lo_drive` change only once per clock on the block clock. The response-time check also assumes that `oc_arm` stays steady while an overcurrent episode is being counted. The asynchronous flags are taken to hold for at least `SYNC_STAGES`+1 cycles whenever they are meant to act. The stimulus drives every input on the falling clock edge. It holds each flag and each clear request for several cycles. It changes `uc_flag` only while `lo_drive` is steady, so each undercurrent sample can be predicted.

// File: rtl/hb_guard_pkg.sv
// Shared types for the half-bridge current guard.
package hb_guard_pkg;

    // Asynchronous inputs that pass through the synchroniser together.
    typedef struct packed {
        logic oc;
        logic uc;
        logic hot;
        logic shut;
        logic uv;
    } async_in_t;

    localparam int ASYNC_W = $bits(async_in_t);

endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchroniser, one chain per bit.
// Assumes the inputs are levels held longer than STAGES cycles.
// The reset value is all zero.
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the asynchronous bit through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/hb_lo_edge.sv
// Detects a 1-to-0 transition of the low-side drive.
// It registers the drive twice and compares the two registered copies.
// Assumes lo_drive is produced on the same clock.
module hb_lo_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_drive,
    output logic lo_fall
);
    logic lo_q1, lo_q2;

    // Keep the current and previous registered low-side levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q1 <= 1'b0;
            lo_q2 <= 1'b0;
        end else begin
            lo_q1 <= lo_drive;
            lo_q2 <= lo_q1;
        end
    end

    assign lo_fall = lo_q2 & ~lo_q1;

    // R4: a falling event needs a high level, then a low level, on the drive input
    lo_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lo_q1) |-> $past(lo_drive) == 1'b0);
endmodule

// File: rtl/hb_fault_core.sv
// Sticky fault latch. Its inputs are the synchronised flags.
// Release (shutdown or UVLO) has priority over every set cause.
module hb_fault_core (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_s,
    input  logic uc_s,
    input  logic hot_s,
    input  logic clr_s,
    input  logic oc_arm,
    input  logic uc_arm,
    input  logic lo_fall,
    output logic trip
);
    logic set_any;

    // Collect the trip causes: continuous overcurrent, sampled undercurrent, heat.
    always_comb begin
        set_any = (oc_arm & oc_s) | (uc_arm & uc_s & lo_fall) | hot_s;
    end

    // Latch update: clear wins, then set, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       trip <= 1'b0;
        else if (clr_s)   trip <= 1'b0;
        else if (set_any) trip <= 1'b1;
    end

    // R11
    clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> !trip);
    // R2
    oc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_arm && oc_s && !clr_s) |=> trip);
    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !clr_s) |=> trip);
    // R6
    hot_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_s && !clr_s) |=> trip);
endmodule

// File: rtl/hb_current_guard.sv
// Top of the half-bridge current guard.
// The asynchronous flags are synchronised. The low-side falling edge is found
// for the undercurrent sample. The fault latch drives the gating of both
// gate drives and of the oscillator enable.
// Assumes the arm inputs and the drives are on clk.
module hb_current_guard #(
    parameter int SYNC_STAGES  = 2,
    parameter int MAX_RESP_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic uc_flag,
    input  logic hot_flag,
    input  logic shut_req,
    input  logic uvlo,
    input  logic oc_arm,
    input  logic uc_arm,
    input  logic lo_drive,
    input  logic hi_drive,
    output logic lo_gate,
    output logic hi_gate,
    output logic osc_run,
    output logic trip
);
    import hb_guard_pkg::*;

    localparam int CNT_W = $clog2(MAX_RESP_CYC + 1);

    async_in_t raw_in, sync_in;
    logic      lo_fall;

    assign raw_in = '{oc: oc_flag, uc: uc_flag, hot: hot_flag,
                      shut: shut_req, uv: uvlo};

    hb_sync #(.W(ASYNC_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    hb_lo_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_drive (lo_drive),
        .lo_fall  (lo_fall)
    );

    hb_fault_core i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .oc_s    (sync_in.oc),
        .uc_s    (sync_in.uc),
        .hot_s   (sync_in.hot),
        .clr_s   (sync_in.shut | sync_in.uv),
        .oc_arm  (oc_arm),
        .uc_arm  (uc_arm),
        .lo_fall (lo_fall),
        .trip    (trip)
    );

    // Block both gates and stop the oscillator while tripped.
    always_comb begin
        lo_gate = lo_drive & ~trip;
        hi_gate = hi_drive & ~trip;
        osc_run = ~trip;
    end

    // Response-time checker: counts the cycles of an armed overcurrent with no clear.
    logic [CNT_W-1:0] oc_age;
    always_ff @(posedge clk) begin
        if (!rst_n)
            oc_age <= '0;
        else if (!(oc_flag && oc_arm) || shut_req || uvlo)
            oc_age <= '0;
        else if (oc_age != CNT_W'(MAX_RESP_CYC))
            oc_age <= oc_age + 1'b1;
    end

    // R2
    oc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_age == CNT_W'(MAX_RESP_CYC)) |-> (!lo_gate && !osc_run));
    // R7
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |=> (trip && !hi_gate && !lo_gate) || !trip);
endmodule

// File: tb/test_hb_current_guard.sv
module test_hb_current_guard;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 0, uc_flag = 0, hot_flag = 0, shut_req = 0, uvlo = 0;
    logic oc_arm = 0, uc_arm = 0, lo_drive = 0, hi_drive = 0;
    logic lo_gate, hi_gate, osc_run, trip;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hb_current_guard i_hb_current_guard (
        .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .uc_flag(uc_flag),
        .hot_flag(hot_flag), .shut_req(shut_req), .uvlo(uvlo),
        .oc_arm(oc_arm), .uc_arm(uc_arm), .lo_drive(lo_drive),
        .hi_drive(hi_drive), .lo_gate(lo_gate), .hi_gate(hi_gate),
        .osc_run(osc_run), .trip(trip)
    );

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    // Advance n rising edges; return at the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        {oc_flag, uc_flag, hot_flag, shut_req, uvlo} = '0;
        {oc_arm, uc_arm, lo_drive, hi_drive} = '0;
        step(3);
        rst_n = 1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk(trip, 0, "R1 trip after reset");
        chk(osc_run, 1, "R1 osc_run after reset");
        lo_drive = 1; hi_drive = 0; #1;
        chk(lo_gate, 1, "R1 lo_gate follows");
        chk(hi_gate, 0, "R1 hi_gate follows");
        lo_drive = 0; hi_drive = 1; #1;
        chk(hi_gate, 1, "R1 hi_gate follows high");
    endtask

    task automatic t_oc_latency();
        do_reset();
        oc_arm = 1; lo_drive = 1; hi_drive = 1;
        oc_flag = 1;
        step(2);
        chk(trip, 0, "R2 not yet tripped after 2 edges");
        step(1);
        chk(trip, 1, "R2 tripped after 3 edges");
        chk(lo_gate, 0, "R7 lo_gate low");
        chk(hi_gate, 0, "R7 hi_gate low");
        chk(osc_run, 0, "R7 osc_run low");
        oc_flag = 0;
        step(6);
        chk(trip, 1, "R8 stays tripped");
    endtask

    task automatic t_oc_disarmed();
        do_reset();
        oc_arm = 0; oc_flag = 1; lo_drive = 1;
        step(8);
        chk(trip, 0, "R3 disarmed overcurrent ignored");
        chk(lo_gate, 1, "R3 lo_gate still driven");
        oc_flag = 0;
    endtask

    task automatic t_uc_fall();
        do_reset();
        uc_arm = 1; lo_drive = 1; uc_flag = 1;
        step(6);
        chk(trip, 0, "R4 no trip while lo_drive high");
        lo_drive = 0;
        step(1);
        chk(trip, 0, "R4 no trip one edge after fall");
        step(1);
        chk(trip, 1, "R4 trip at sampled fall");
        uc_flag = 0;
    endtask

    task automatic t_uc_low_steady();
        do_reset();
        uc_arm = 1; lo_drive = 0; uc_flag = 1;
        step(8);
        chk(trip, 0, "R4 no trip while lo_drive low");
        lo_drive = 1; step(4);
        uc_flag = 0; step(3);
        lo_drive = 0; step(4);
        chk(trip, 0, "R4 fall with flag low");
    endtask

    task automatic t_uc_disarmed();
        do_reset();
        uc_arm = 0; lo_drive = 1; uc_flag = 1;
        step(4);
        lo_drive = 0;
        step(4);
        chk(trip, 0, "R5 disarmed undercurrent ignored");
        uc_flag = 0;
    endtask

    task automatic t_hot();
        do_reset();
        hot_flag = 1;
        step(3);
        chk(trip, 1, "R6 over-temperature trips");
        hot_flag = 0;
        step(4);
        chk(trip, 1, "R8 stays after heat clears");
    endtask

    task automatic t_shut_clear();
        do_reset();
        hot_flag = 1; step(3); hot_flag = 0; step(2);
        shut_req = 1;
        step(2);
        chk(trip, 1, "R9 still tripped during sync");
        step(1);
        chk(trip, 0, "R9 shutdown clears");
        shut_req = 0; step(3);
        chk(osc_run, 1, "R9 oscillator re-enabled");
    endtask

    task automatic t_uvlo_clear();
        do_reset();
        oc_arm = 1; oc_flag = 1; step(4); oc_flag = 0; step(2);
        chk(trip, 1, "R10 tripped before uvlo");
        uvlo = 1;
        step(3);
        chk(trip, 0, "R10 uvlo clears");
        uvlo = 0; step(2);
    endtask

    task automatic t_priority();
        do_reset();
        shut_req = 1; step(4);
        oc_arm = 1; oc_flag = 1; hot_flag = 1;
        step(6);
        chk(trip, 0, "R11 clear beats set");
        shut_req = 0;
        step(3);
        chk(trip, 1, "R11 sets once clear releases");
        oc_flag = 0; hot_flag = 0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_oc_latency();
                t_oc_disarmed();
                t_uc_fall();
                t_uc_low_steady();
                t_uc_disarmed();
                t_hot();
                t_shut_clear();
                t_uvlo_clear();
                t_priority();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule